// File: doc/BRIEF.md
# Parallel Display Bus Sequencer

This block drives a parallel panel bus made of four control lines: chip select, an address/command select line, a write strobe and a read strobe. All strobes and the select are active low. Requests come from two sources. One is a pixel stream from a display controller, which always writes display data. The other is a slave port that may issue any of the four bus functions. When both sources are valid in the same cycle, the display controller wins.

Each accepted request occupies the bus for a fixed number of clock cycles. That number is the minimum cycle time, and it is looked up from three things: the source, the selected cycle format and, for the slave port, whether it packs one or two pixels per word. The select line is stable for the whole transfer. The strobe falls one cycle after the transfer starts and rises one cycle before it ends. Back-to-back requests keep chip select low across the whole burst. Read data is sampled on the edge where the read strobe rises, and it is returned with a one-cycle valid pulse.

Top module: `pbus_seq`

## Requirements
- R1: After reset, cs_no, we_no and re_no are high, bus_oe_o and rd_valid_o are low, and dc_ready_o is high.
- R2: The function code (0 data/parameter write, 1 data read, 2 status read, 3 command write) sets the lines during the strobe as follows. Code 0 gives a0=1 with the write strobe. Code 1 gives a0=1 with the read strobe. Code 2 gives a0=0 with the read strobe. Code 3 gives a0=0 with the write strobe. The two strobes are never low together.
- R3: Each transfer lasts P cycles with chip select low. The single strobe pulse is low for P-2 cycles. It is high in the first and last cycle of the transfer, and a0 does not change while the strobe is low.
- R4: For a display-controller request, P is 4, 3, 3 and 6 for cycle format codes 0 (1 pixel/cycle), 1 (1 pixel/2 cycles), 2 (1 pixel/3 cycles) and 3 (2 pixels/3 cycles).
- R5: For a slave-port request with one-pixel packing (cfg_pack2_i=0), P is 5, 4, 4 and 6 for format codes 0 to 3.
- R6: For a slave-port request with two-pixel packing (cfg_pack2_i=1), P is 4, 4, 4 and 6 for format codes 0 to 3.
- R7: A request accepted in the last cycle of the current transfer follows it with chip select held low. Chip select rises when no request is pending at that point.
- R8: Ready is low during the non-final cycles of a transfer, so consecutive strobe falls of a burst are exactly P cycles apart.
- R9: While dc_valid_i is high, sp_ready_o is low.
- R10: For a read, bus_din_i is captured on the clock edge where the read strobe rises. rd_valid_o is then high for exactly one cycle, with that value on rd_data_o.
- R11: bus_oe_o is high and bus_dout_o carries the request data during a write transfer. bus_oe_o is low during reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interconnect clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_fmt_i | input | 2 | Cycle format code |
| cfg_pack2_i | input | 1 | Slave port packs two pixels per word |
| dc_valid_i | input | 1 | Display controller pixel valid |
| dc_ready_o | output | 1 | Display controller pixel accepted |
| dc_data_i | input | DW | Display controller pixel |
| sp_valid_i | input | 1 | Slave port request valid |
| sp_ready_o | output | 1 | Slave port request accepted |
| sp_fn_i | input | 2 | Slave port bus function code |
| sp_data_i | input | DW | Slave port write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DW | Captured read data |
| cs_no | output | 1 | Chip select, active low |
| a0_o | output | 1 | Data (1) / command-status (0) select |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| bus_oe_o | output | 1 | Data bus output enable |
| bus_dout_o | output | DW | Data bus output |
| bus_din_i | input | DW | Data bus input |

## Verification
The bench walks every source, packing and format combination. For each one it measures the chip-select window and the strobe width. A wrong lookup entry shows up as a window one or more cycles off, and an off-by-one in the strobe window shows up as a pulse that touches the first or last cycle. Back-to-back display pixels are sent with a slave request pending the whole time. A sequencer that released chip select between pixels, accepted early, or let the slave port through would show extra chip-select rises, uneven strobe spacing or a slave ready pulse. Reads check that the captured value and its single valid pulse arrive while the strobe rises, not a cycle earlier or later.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [1:0] {
    FN_DATA_WR = 2'd0,
    FN_DATA_RD = 2'd1,
    FN_STAT_RD = 2'd2,
    FN_CMD_WR  = 2'd3
  } bus_fn_e;

  typedef enum logic [1:0] {
    FMT_1P1C = 2'd0,
    FMT_1P2C = 2'd1,
    FMT_1P3C = 2'd2,
    FMT_2P3C = 2'd3
  } cyc_fmt_e;

  function automatic logic fn_a0(bus_fn_e f);
    return (f == FN_DATA_WR) || (f == FN_DATA_RD);
  endfunction

  function automatic logic fn_wr(bus_fn_e f);
    return (f == FN_DATA_WR) || (f == FN_CMD_WR);
  endfunction

  // minimum transfer length in clocks
  function automatic logic [CNT_W-1:0] min_period(logic from_dc, cyc_fmt_e fmt, logic pack2);
    logic [CNT_W-1:0] p;
    case (fmt)
      FMT_1P1C: p = from_dc ? CNT_W'(4) : (pack2 ? CNT_W'(4) : CNT_W'(5));
      FMT_1P2C,
      FMT_1P3C: p = from_dc ? CNT_W'(3) : CNT_W'(4);
      default:  p = CNT_W'(6);
    endcase
    return p;
  endfunction
endpackage

// File: rtl/pbus_arb.sv
module pbus_arb
  import pbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          dc_valid_i,
  input  logic [DW-1:0] dc_data_i,
  input  logic          sp_valid_i,
  input  logic [1:0]    sp_fn_i,
  input  logic [DW-1:0] sp_data_i,
  input  logic          take_i,
  output logic          dc_ready_o,
  output logic          sp_ready_o,
  output logic          req_o,
  output logic          sel_dc_o,
  output bus_fn_e       fn_o,
  output logic [DW-1:0] data_o
);
  // display controller has fixed priority
  assign sel_dc_o   = dc_valid_i;
  assign req_o      = dc_valid_i | sp_valid_i;
  assign dc_ready_o = take_i;
  assign sp_ready_o = take_i & ~dc_valid_i;
  assign fn_o       = dc_valid_i ? FN_DATA_WR : bus_fn_e'(sp_fn_i);
  assign data_o     = dc_valid_i ? dc_data_i : sp_data_i;
endmodule

// File: rtl/pbus_timer.sv
module pbus_timer
  import pbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] period_o,
  output logic             last_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, per_q;

  assign last_o   = busy_q && (cnt_q == per_q - CNT_W'(1));
  assign busy_o   = busy_q;
  assign cnt_o    = cnt_q;
  assign period_o = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      per_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      per_q  <= period_i;
    end else if (last_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cfg_fmt_i,
  input  logic          cfg_pack2_i,
  input  logic          dc_valid_i,
  output logic          dc_ready_o,
  input  logic [DW-1:0] dc_data_i,
  input  logic          sp_valid_i,
  output logic          sp_ready_o,
  input  logic [1:0]    sp_fn_i,
  input  logic [DW-1:0] sp_data_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          cs_no,
  output logic          a0_o,
  output logic          we_no,
  output logic          re_no,
  output logic          bus_oe_o,
  output logic [DW-1:0] bus_dout_o,
  input  logic [DW-1:0] bus_din_i
);
  logic             req, sel_dc, take, accept;
  bus_fn_e          req_fn, fn_q;
  logic [DW-1:0]    req_data, data_q;
  logic             busy, last;
  logic [CNT_W-1:0] cnt, per;
  logic             strobe_on, capture;

  assign take   = !busy || last;
  assign accept = req && take;

  pbus_arb #(.DW(DW)) i_arb (
    .dc_valid_i (dc_valid_i),
    .dc_data_i  (dc_data_i),
    .sp_valid_i (sp_valid_i),
    .sp_fn_i    (sp_fn_i),
    .sp_data_i  (sp_data_i),
    .take_i     (take),
    .dc_ready_o (dc_ready_o),
    .sp_ready_o (sp_ready_o),
    .req_o      (req),
    .sel_dc_o   (sel_dc),
    .fn_o       (req_fn),
    .data_o     (req_data)
  );

  pbus_timer i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (accept),
    .period_i (min_period(sel_dc, cyc_fmt_e'(cfg_fmt_i), cfg_pack2_i)),
    .busy_o   (busy),
    .cnt_o    (cnt),
    .period_o (per),
    .last_o   (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q   <= FN_DATA_WR;
      data_q <= '0;
    end else if (accept) begin
      fn_q   <= req_fn;
      data_q <= req_data;
    end
  end

  // strobe low from the second cycle up to the one before last
  assign strobe_on = busy && (cnt != '0) && !last;
  // read strobe rises at the edge closing cnt == per-2
  assign capture   = busy && !fn_wr(fn_q) && (cnt == per - CNT_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= capture;
      if (capture) rd_data_o <= bus_din_i;
    end
  end

  assign cs_no      = !busy;
  assign a0_o       = busy ? fn_a0(fn_q) : 1'b1;
  assign we_no      = !(strobe_on && fn_wr(fn_q));
  assign re_no      = !(strobe_on && !fn_wr(fn_q));
  assign bus_oe_o   = busy && fn_wr(fn_q);
  assign bus_dout_o = data_q;
endmodule

// File: rtl/pbus_seq_chk.sv
module pbus_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dc_valid_i,
  input logic sp_ready_o,
  input logic rd_valid_o,
  input logic cs_no,
  input logic a0_o,
  input logic we_no,
  input logic re_no,
  input logic bus_oe_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no)); // R2
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (we_no && re_no)); // R3
  AST_A0_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_no || !re_no) |=> ((we_no && re_no) || $stable(a0_o))); // R3
  AST_DC_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_valid_i |-> !sp_ready_o); // R9
  AST_RD_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o); // R10
  AST_RD_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (re_no && $past(!re_no))); // R10
  AST_OE_NOT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> re_no); // R11
endmodule

bind pbus_seq pbus_seq_chk i_pbus_seq_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dc_valid_i (dc_valid_i),
  .sp_ready_o (sp_ready_o),
  .rd_valid_o (rd_valid_o),
  .cs_no      (cs_no),
  .a0_o       (a0_o),
  .we_no      (we_no),
  .re_no      (re_no),
  .bus_oe_o   (bus_oe_o)
);

// File: tb/test_pbus_seq.sv
`timescale 1ns/1ps
module test_pbus_seq;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    cfg_fmt_i = '0;
  logic          cfg_pack2_i = 1'b0;
  logic          dc_valid_i = 1'b0;
  logic          dc_ready_o;
  logic [DW-1:0] dc_data_i = '0;
  logic          sp_valid_i = 1'b0;
  logic          sp_ready_o;
  logic [1:0]    sp_fn_i = '0;
  logic [DW-1:0] sp_data_i = '0;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic          cs_no, a0_o, we_no, re_no, bus_oe_o;
  logic [DW-1:0] bus_dout_o;
  logic [DW-1:0] bus_din_i = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  pbus_seq #(.DW(DW)) i_pbus_seq (.*);

  // {from_dc, fmt, pack2, fn, expected period}
  localparam logic [8:0] VEC [12] = '{
    {1'b1, 2'd0, 1'b0, 2'd0, 3'd4},
    {1'b1, 2'd1, 1'b0, 2'd0, 3'd3},
    {1'b1, 2'd2, 1'b0, 2'd0, 3'd3},
    {1'b1, 2'd3, 1'b0, 2'd0, 3'd6},
    {1'b0, 2'd0, 1'b0, 2'd3, 3'd5},
    {1'b0, 2'd1, 1'b0, 2'd1, 3'd4},
    {1'b0, 2'd2, 1'b0, 2'd2, 3'd4},
    {1'b0, 2'd3, 1'b0, 2'd0, 3'd6},
    {1'b0, 2'd0, 1'b1, 2'd1, 3'd4},
    {1'b0, 2'd1, 1'b1, 2'd3, 3'd4},
    {1'b0, 2'd2, 1'b1, 2'd0, 3'd4},
    {1'b0, 2'd3, 1'b1, 2'd2, 3'd6}
  };

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(input logic from_dc, input logic [1:0] fmt, input logic pack2,
                         input logic [1:0] fn, input int per, input logic [DW-1:0] pat);
    string rp;
    int cs_lo, st_lo, wrong, a0_bad, rdv, oe_bad, a0_edge;
    logic [DW-1:0] rdd;
    logic is_wr, exp_a0;
    rp = from_dc ? "R4" : (pack2 ? "R6" : "R5");
    is_wr = (fn == 2'd0) || (fn == 2'd3);
    exp_a0 = (fn == 2'd0) || (fn == 2'd1);
    cs_lo = 0; st_lo = 0; wrong = 0; a0_bad = 0; rdv = 0; oe_bad = 0; a0_edge = 0; rdd = '0;
    @(negedge clk_i);
    cfg_fmt_i = fmt; cfg_pack2_i = pack2; bus_din_i = ~pat;
    if (from_dc) begin dc_valid_i = 1'b1; dc_data_i = pat; end
    else begin sp_valid_i = 1'b1; sp_fn_i = fn; sp_data_i = pat; end
    #1;
    chk("R8", from_dc ? dc_ready_o : sp_ready_o, 0, 1);
    @(negedge clk_i);
    dc_valid_i = 1'b0; sp_valid_i = 1'b0;
    for (int k = 0; k < 12 && !cs_no; k++) begin
      cs_lo++;
      if (!we_no || !re_no) begin
        st_lo++;
        if (k == 0 || k == per - 1) a0_edge++;
        if (a0_o !== exp_a0) a0_bad++;
        if (is_wr ? !re_no : !we_no) wrong++;
      end
      if (is_wr && (!bus_oe_o || bus_dout_o !== pat)) oe_bad++;
      if (!is_wr && bus_oe_o) oe_bad++;
      if (rd_valid_o) begin rdv++; rdd = rd_data_o; end
      @(negedge clk_i);
    end
    chk(rp, cs_lo == per, cs_lo, per);
    chk("R3", st_lo == per - 2 && a0_edge == 0, st_lo, per - 2);
    chk("R2", a0_bad == 0 && wrong == 0, a0_bad + wrong, 0);
    chk("R11", oe_bad == 0, oe_bad, 0);
    if (!is_wr) begin
      chk("R10", rdv == 1, rdv, 1);
      chk("R10", rdd === ~pat, int'(rdd), int'(~pat));
    end else begin
      chk("R10", rdv == 0, rdv, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", cs_no && we_no && re_no && !bus_oe_o && !rd_valid_o, 0, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", cs_no && we_no && re_no && dc_ready_o, 0, 1);

    foreach (VEC[i]) begin
      run_one(VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4:3], int'(VEC[i][2:0]),
              DW'(16'h1000 + 16'(i) * 16'h0111));
    end

    // R9: simultaneous request at idle
    @(negedge clk_i);
    cfg_fmt_i = 2'd1; cfg_pack2_i = 1'b0;
    dc_valid_i = 1'b1; dc_data_i = 16'hA000;
    sp_valid_i = 1'b1; sp_fn_i = 2'd3; sp_data_i = 16'h5555;
    #1;
    chk("R9", dc_ready_o && !sp_ready_o, int'(sp_ready_o), 0);

    // R7/R8/R9: three-pixel burst with slave request pending throughout
    begin
      int n_acc, cs_lo, cs_rise, falls, sp_rdy, k, sp_bad;
      int fall_at [3];
      logic prev_we, prev_cs, started;
      n_acc = 0; cs_lo = 0; cs_rise = 0; falls = 0; sp_rdy = 0; k = 0; sp_bad = 0;
      prev_we = 1'b1; prev_cs = 1'b1; started = 1'b0;
      for (int c = 0; c < 40; c++) begin
        if (n_acc == 3) begin dc_valid_i = 1'b0; sp_valid_i = 1'b0; end
        if (!cs_no) begin cs_lo++; started = 1'b1; end
        if (cs_no && !prev_cs) cs_rise++;
        if (!we_no && prev_we) begin
          if (falls < 3) fall_at[falls] = k;
          falls++;
        end
        if (sp_ready_o && dc_valid_i) sp_bad++;
        if (bus_dout_o !== 16'h5555 && !bus_oe_o) sp_rdy = sp_rdy;
        prev_we = we_no; prev_cs = cs_no; k++;
        if (dc_valid_i && dc_ready_o) begin
          n_acc++;
          dc_data_i = dc_data_i + 16'h1;
        end
        if (n_acc == 3 && started && cs_no) break;
        @(negedge clk_i);
      end
      chk("R7", cs_lo == 9, cs_lo, 9);
      chk("R7", cs_rise == 1, cs_rise, 1);
      chk("R8", falls == 3, falls, 3);
      chk("R8", fall_at[1] - fall_at[0] == 3 && fall_at[2] - fall_at[1] == 3,
          fall_at[2] - fall_at[0], 6);
      chk("R9", sp_bad == 0, sp_bad, 0);
    end

    // R1: reset in the middle of a transfer returns to idle
    @(negedge clk_i);
    cfg_fmt_i = 2'd3; sp_valid_i = 1'b1; sp_fn_i = 2'd1;
    @(negedge clk_i);
    sp_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1", cs_no && we_no && re_no && !rd_valid_o, int'(cs_no), 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (8) @(negedge clk_i);
    chk("R1", cs_no && !rd_valid_o, int'(rd_valid_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule